// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port with Alternate Functions

This block models one 8-bit general-purpose I/O port of a small microcontroller at register level. Each pin bit has an output latch that the CPU writes either as a whole byte or one bit at a time. Two read paths exist. One samples the pin level and one returns the latch, which is the value read-modify-write sequences need. A pin is modelled as three indications: a strong pull to ground, a weak pull toward the supply, and a strong drive high. When none of the three is active, the pin floats. A pin works as an input only while its latch holds 1, because a latch 0 turns on the pull-down and holds the pin low.

A parameter selects one of three variants. The plain variant has an internal pull-up, so a latch 1 gives a weak high. The alternate-function variant also has a pull-up, and it drives the AND of the latch and a per-bit alternate output line. No mode select is needed: a peripheral that uses a pin leaves its latch at 1. When the latch is at 1, the peripheral's line reaches the pin. When the peripheral line idles at 1, the latch reaches the pin. The bus variant has no pull-up, so in general use a latch 1 floats. While external memory access is active, this variant drives the low address byte and then carries data strongly in both directions, and the latch has no effect. In every variant the pin level feeds the alternate-function inputs directly, alongside the normal read path.

Top module: `qb_port`

## Requirements
- R1: After reset every latch bit is 1. The plain and alternate variants then show weak high on all pins with no pull-down. The bus variant shows all pins floating.
- R2: A byte write loads all 8 latch bits at the clock edge where the write enable is sampled. The new drive is visible right after that edge.
- R3: A bit write changes only the latch bit picked by the 3-bit select (0 = LSB). When a byte write and a bit write occur in the same cycle, the bit write sets its own position and the byte write sets the other positions.
- R4: On the alternate variant, bit i is pulled low exactly when (latch[i] AND alt_out[i]) is 0.
- R5: On the plain and alternate variants, a bit whose effective value is 1 has weak high asserted and strong high deasserted.
- R6: A pin read captures pin_in at the strobe edge. rd_data carries that value with rd_valid high for exactly the one cycle after the strobe, and rd_valid is low when no strobe was given.
- R7: A latch read returns the latch regardless of the pin level. If both read strobes are given together, the latch read wins.
- R8: alt_in equals pin_in combinationally on every variant.
- R9: On the bus variant outside external access, a latch 0 pulls the pin low and a latch 1 leaves the pin floating (no weak or strong high).
- R10: On the bus variant during external access in the address phase, the pins carry ext_addr_lo strongly: a 0 bit pulls low and a 1 bit drives strong high, independent of the latch. The other variants ignore the external access inputs.
- R11: On the bus variant during external access in the data phase, the pins carry ext_data_out strongly while ext_data_oe is 1. While ext_data_oe is 0, all pins float.
- R12: No pin is ever pulled low while a weak or strong high is also asserted on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_byte_en | input | 1 | Byte write enable |
| wr_byte_data | input | 8 | Byte write value |
| wr_bit_en | input | 1 | Single-bit write enable |
| wr_bit_sel | input | 3 | Bit position for the bit write |
| wr_bit_val | input | 1 | Value for the bit write |
| rd_pin_stb | input | 1 | Request a pin-level read |
| rd_latch_stb | input | 1 | Request a latch read |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid, one cycle after a strobe |
| pin_in | input | 8 | Sensed pin levels |
| alt_out | input | 8 | Alternate-function output lines (idle 1) |
| alt_in | output | 8 | Alternate-function input lines (pin level) |
| ext_mode | input | 1 | External memory access active |
| ext_addr_phase | input | 1 | 1 = address phase, 0 = data phase |
| ext_addr_lo | input | 8 | Low address byte |
| ext_data_out | input | 8 | Data to drive in the data phase |
| ext_data_oe | input | 1 | Drive data in the data phase |
| pin_pull_low | output | 8 | Strong pull to ground per pin |
| pin_weak_high | output | 8 | Weak pull-up active per pin |
| pin_strong_high | output | 8 | Strong drive high per pin |

## Verification
Writes are registered once. The pin indications depend combinationally on the latch and the alternate and bus inputs, so their effect on the pins is due right after the write edge. Changes on the alternate or bus inputs alone show up in the same cycle. A read result is due one edge after its strobe, and rd_valid drops again at the following edge. The bench drives inputs on the falling edge and samples on the next falling edge. This places every sample after exactly one rising edge, or after none for the combinational paths.

// File: rtl/qb_port_pkg.sv
package qb_port_pkg;
  typedef enum logic [1:0] {
    QB_PLAIN  = 2'd0,
    QB_ALTFN  = 2'd1,
    QB_MUXBUS = 2'd2
  } qb_variant_e;
endpackage

// File: rtl/qb_latch.sv
module qb_latch #(
  parameter int WIDTH = 8,
  localparam int SEL_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_byte_en,
  input  logic [WIDTH-1:0] wr_byte_data,
  input  logic             wr_bit_en,
  input  logic [SEL_W-1:0] wr_bit_sel,
  input  logic             wr_bit_val,
  output logic [WIDTH-1:0] latch_q
);
  logic [WIDTH-1:0] latch_nxt;

  always_comb begin
    latch_nxt = latch_q;
    if (wr_byte_en) latch_nxt = wr_byte_data;
    if (wr_bit_en)  latch_nxt[wr_bit_sel] = wr_bit_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) latch_q <= '1;
    else        latch_q <= latch_nxt;
  end

  // R2: a lone byte write lands in the latch
  assert_byte_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte_en && !wr_bit_en) |=> latch_q == $past(wr_byte_data));

  // R3: a lone bit write leaves the other bits alone
  assert_bit_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bit_en && !wr_byte_en) |=>
      ((latch_q ^ $past(latch_q)) & ~(WIDTH'(1) << $past(wr_bit_sel))) == '0);

  // R3: the selected bit takes the written value, even with a byte write
  assert_bit_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bit_en |=> latch_q[$past(wr_bit_sel)] == $past(wr_bit_val));
endmodule

// File: rtl/qb_drive.sv
module qb_drive
  import qb_port_pkg::*;
#(
  parameter int          WIDTH   = 8,
  parameter qb_variant_e VARIANT = QB_ALTFN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] alt_out,
  input  logic             ext_mode,
  input  logic             ext_addr_phase,
  input  logic [WIDTH-1:0] ext_addr_lo,
  input  logic [WIDTH-1:0] ext_data_out,
  input  logic             ext_data_oe,
  output logic [WIDTH-1:0] pin_pull_low,
  output logic [WIDTH-1:0] pin_weak_high,
  output logic [WIDTH-1:0] pin_strong_high
);
  localparam bit HAS_ALT    = (VARIANT == QB_ALTFN);
  localparam bit HAS_PULLUP = (VARIANT != QB_MUXBUS);
  localparam bit IS_BUS     = (VARIANT == QB_MUXBUS);

  logic [WIDTH-1:0] eff;
  logic [WIDTH-1:0] bus_val;
  logic             bus_en;
  logic             bus_active;

  assign eff        = latch_q & (HAS_ALT ? alt_out : {WIDTH{1'b1}});
  assign bus_val    = ext_addr_phase ? ext_addr_lo : ext_data_out;
  assign bus_en     = ext_addr_phase | ext_data_oe;
  assign bus_active = IS_BUS & ext_mode;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      pin_pull_low[i]    = ~eff[i];
      pin_weak_high[i]   = HAS_PULLUP & eff[i];
      pin_strong_high[i] = 1'b0;
      if (bus_active) begin
        pin_pull_low[i]    = bus_en & ~bus_val[i];
        pin_strong_high[i] = bus_en & bus_val[i];
        pin_weak_high[i]   = 1'b0;
      end
    end
  end

  // R12: never fight the pull-down
  assert_no_contention_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pull_low & (pin_weak_high | pin_strong_high)) == '0);

  if (HAS_ALT) begin : g_chk_alt
    // R4: pull-down follows latch AND alternate line
    assert_alt_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pin_pull_low == ~(latch_q & alt_out));
  end

  if (IS_BUS) begin : g_chk_bus
    // R9: no high drive of any kind in general use
    assert_open_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_mode |-> (pin_weak_high | pin_strong_high) == '0);
    // R10: address phase carries the address strongly
    assert_addr_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mode && ext_addr_phase) |-> (pin_strong_high == ext_addr_lo && pin_pull_low == ~ext_addr_lo));
    // R11: released bus floats
    assert_bus_float_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mode && !ext_addr_phase && !ext_data_oe) |-> (pin_pull_low | pin_strong_high | pin_weak_high) == '0);
  end else begin : g_chk_quasi
    // R5: effective 1 gives a weak high only
    assert_weak_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_strong_high == '0) && (pin_weak_high == ~pin_pull_low));
  end
endmodule

// File: rtl/qb_readback.sv
module qb_readback #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_pin_stb,
  input  logic             rd_latch_stb,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_pin_stb | rd_latch_stb;
      if (rd_latch_stb)    rd_data <= latch_q;
      else if (rd_pin_stb) rd_data <= pin_in;
    end
  end

  // R6: pin read returns the sampled level
  assert_pin_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pin_stb && !rd_latch_stb) |=> (rd_valid && rd_data == $past(pin_in)));

  // R6: no strobe, no valid
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pin_stb || rd_latch_stb) |=> !rd_valid);

  // R7: latch read wins
  assert_latch_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch_stb |=> (rd_valid && rd_data == $past(latch_q)));
endmodule

// File: rtl/qb_port.sv
module qb_port
  import qb_port_pkg::*;
#(
  parameter qb_variant_e VARIANT = QB_ALTFN,
  parameter int          WIDTH   = 8,
  localparam int         SEL_W   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_byte_en,
  input  logic [WIDTH-1:0] wr_byte_data,
  input  logic             wr_bit_en,
  input  logic [SEL_W-1:0] wr_bit_sel,
  input  logic             wr_bit_val,
  input  logic             rd_pin_stb,
  input  logic             rd_latch_stb,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] alt_out,
  output logic [WIDTH-1:0] alt_in,
  input  logic             ext_mode,
  input  logic             ext_addr_phase,
  input  logic [WIDTH-1:0] ext_addr_lo,
  input  logic [WIDTH-1:0] ext_data_out,
  input  logic             ext_data_oe,
  output logic [WIDTH-1:0] pin_pull_low,
  output logic [WIDTH-1:0] pin_weak_high,
  output logic [WIDTH-1:0] pin_strong_high
);
  logic [WIDTH-1:0] latch_q;

  qb_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
    .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel), .wr_bit_val(wr_bit_val),
    .latch_q(latch_q)
  );

  qb_drive #(.WIDTH(WIDTH), .VARIANT(VARIANT)) u_drive (
    .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .alt_out(alt_out),
    .ext_mode(ext_mode), .ext_addr_phase(ext_addr_phase),
    .ext_addr_lo(ext_addr_lo), .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe),
    .pin_pull_low(pin_pull_low), .pin_weak_high(pin_weak_high),
    .pin_strong_high(pin_strong_high)
  );

  qb_readback #(.WIDTH(WIDTH)) u_read (
    .clk(clk), .rst_n(rst_n), .rd_pin_stb(rd_pin_stb), .rd_latch_stb(rd_latch_stb),
    .pin_in(pin_in), .latch_q(latch_q), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R8: alternate inputs tap the pin in parallel with the read path
  assign alt_in = pin_in;

  // R8: the alternate input equals the pin level
  always_comb begin
    if (rst_n) assert_alt_in_R8: assert (alt_in == pin_in);
  end
endmodule

// File: tb/test_qb_port.sv
module test_qb_port;
  import qb_port_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_byte_en = 0, wr_bit_en = 0, wr_bit_val = 0;
  logic [7:0] wr_byte_data = 0;
  logic [2:0] wr_bit_sel = 0;
  logic rd_pin_stb = 0, rd_latch_stb = 0;
  logic [7:0] pin_in = 8'hFF, alt_out = 8'hFF;
  logic ext_mode = 0, ext_addr_phase = 0, ext_data_oe = 0;
  logic [7:0] ext_addr_lo = 0, ext_data_out = 0;

  logic [7:0] a_rd, a_alt_in, a_lo, a_wk, a_st;
  logic       a_rv;
  logic [7:0] m_rd, m_alt_in, m_lo, m_wk, m_st;
  logic       m_rv;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qb_port #(.VARIANT(QB_ALTFN)) i_qb_port (
    .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
    .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel), .wr_bit_val(wr_bit_val),
    .rd_pin_stb(rd_pin_stb), .rd_latch_stb(rd_latch_stb), .rd_data(a_rd), .rd_valid(a_rv),
    .pin_in(pin_in), .alt_out(alt_out), .alt_in(a_alt_in),
    .ext_mode(ext_mode), .ext_addr_phase(ext_addr_phase), .ext_addr_lo(ext_addr_lo),
    .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe),
    .pin_pull_low(a_lo), .pin_weak_high(a_wk), .pin_strong_high(a_st)
  );

  qb_port #(.VARIANT(QB_MUXBUS)) i_qb_port_mux (
    .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
    .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel), .wr_bit_val(wr_bit_val),
    .rd_pin_stb(rd_pin_stb), .rd_latch_stb(rd_latch_stb), .rd_data(m_rd), .rd_valid(m_rv),
    .pin_in(pin_in), .alt_out(alt_out), .alt_in(m_alt_in),
    .ext_mode(ext_mode), .ext_addr_phase(ext_addr_phase), .ext_addr_lo(ext_addr_lo),
    .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe),
    .pin_pull_low(m_lo), .pin_weak_high(m_wk), .pin_strong_high(m_st)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic no_fight();
    chk("R12", "alt contention", a_lo & (a_wk | a_st), 8'h00);
    chk("R12", "bus contention", m_lo & (m_wk | m_st), 8'h00);
  endtask

  task automatic put_byte(input logic [7:0] v);
    wr_byte_en = 1; wr_byte_data = v;
    @(negedge clk);
    wr_byte_en = 0;
  endtask

  task automatic put_bit(input logic [2:0] s, input logic v);
    wr_bit_en = 1; wr_bit_sel = s; wr_bit_val = v;
    @(negedge clk);
    wr_bit_en = 0;
  endtask

  task automatic read_latch(output logic [7:0] v, output logic vld);
    rd_latch_stb = 1;
    @(negedge clk);
    rd_latch_stb = 0;
    v = a_rd; vld = a_rv;
  endtask

  task automatic t_reset();
    logic [7:0] v; logic vld;
    chk("R1", "alt pull low", a_lo, 8'h00);
    chk("R1", "alt weak high", a_wk, 8'hFF);
    chk("R1", "bus weak high", m_wk, 8'h00);
    chk("R1", "bus pull low", m_lo | m_st, 8'h00);
    read_latch(v, vld);
    chk("R1", "latch after reset", v, 8'hFF);
    no_fight();
  endtask

  task automatic t_byte_write();
    logic [7:0] v; logic vld;
    put_byte(8'hA5);
    chk("R2", "pull low after byte write", a_lo, 8'h5A);
    chk("R5", "weak high", a_wk, 8'hA5);
    chk("R5", "strong high", a_st, 8'h00);
    read_latch(v, vld);
    chk("R2", "latch readback", v, 8'hA5);
    put_byte(8'h00);
    chk("R2", "all low", a_lo, 8'hFF);
    no_fight();
  endtask

  task automatic t_bit_write();
    logic [7:0] v; logic vld;
    put_byte(8'hA5);
    put_bit(3'd1, 1'b1);
    read_latch(v, vld);
    chk("R3", "set bit 1", v, 8'hA7);
    put_bit(3'd7, 1'b0);
    read_latch(v, vld);
    chk("R3", "clear bit 7", v, 8'h27);
    wr_byte_en = 1; wr_byte_data = 8'h00;
    wr_bit_en = 1; wr_bit_sel = 3'd3; wr_bit_val = 1'b1;
    @(negedge clk);
    wr_byte_en = 0; wr_bit_en = 0;
    read_latch(v, vld);
    chk("R3", "byte and bit together", v, 8'h08);
    wr_byte_en = 1; wr_byte_data = 8'hFF;
    wr_bit_en = 1; wr_bit_sel = 3'd0; wr_bit_val = 1'b0;
    @(negedge clk);
    wr_byte_en = 0; wr_bit_en = 0;
    chk("R3", "bit 0 cleared over byte", a_lo, 8'h01);
  endtask

  task automatic t_alt();
    put_byte(8'hFF);
    alt_out = 8'h0F;
    #1;
    chk("R4", "alt line to pin", a_lo, 8'hF0);
    chk("R5", "weak from alt", a_wk, 8'h0F);
    put_byte(8'h3C);
    chk("R4", "latch and alt", a_lo, 8'hF3);
    alt_out = 8'hFF;
    #1;
    chk("R4", "latch to pin", a_lo, 8'hC3);
    chk("R4", "bus ignores alt", m_lo, 8'hC3);
    no_fight();
  endtask

  task automatic t_reads();
    logic [7:0] v; logic vld;
    put_byte(8'hF0);
    pin_in = 8'h3C;
    rd_pin_stb = 1;
    @(negedge clk);
    rd_pin_stb = 0;
    chk("R6", "pin read data", a_rd, 8'h3C);
    chk("R6", "pin read valid", {7'd0, a_rv}, 8'h01);
    @(negedge clk);
    chk("R6", "valid drops", {7'd0, a_rv}, 8'h00);
    pin_in = 8'h00;
    read_latch(v, vld);
    chk("R7", "latch not pin", v, 8'hF0);
    chk("R7", "latch read valid", {7'd0, vld}, 8'h01);
    rd_pin_stb = 1; rd_latch_stb = 1;
    @(negedge clk);
    rd_pin_stb = 0; rd_latch_stb = 0;
    chk("R7", "latch wins", a_rd, 8'hF0);
  endtask

  task automatic t_alt_in();
    pin_in = 8'h96;
    #1;
    chk("R8", "alt_in", a_alt_in, 8'h96);
    pin_in = 8'h21;
    #1;
    chk("R8", "alt_in bus variant", m_alt_in, 8'h21);
  endtask

  task automatic t_bus();
    put_byte(8'h0F);
    chk("R9", "bus pull low", m_lo, 8'hF0);
    chk("R9", "bus no high", m_wk | m_st, 8'h00);
    ext_mode = 1; ext_addr_phase = 1; ext_addr_lo = 8'h5A;
    #1;
    chk("R10", "addr low", m_lo, 8'hA5);
    chk("R10", "addr high", m_st, 8'h5A);
    chk("R10", "alt variant ignores ext", a_lo, 8'hF0);
    chk("R10", "alt variant no strong", a_st, 8'h00);
    no_fight();
    ext_addr_phase = 0; ext_data_out = 8'hC3; ext_data_oe = 1;
    #1;
    chk("R11", "data low", m_lo, 8'h3C);
    chk("R11", "data high", m_st, 8'hC3);
    ext_data_oe = 0;
    #1;
    chk("R11", "released", m_lo | m_st | m_wk, 8'h00);
    no_fight();
    ext_mode = 0;
    #1;
    chk("R9", "back to latch", m_lo, 8'hF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_bit_write();
    t_alt();
    t_reads();
    t_alt_in();
    t_bus();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule